// File: doc/BRIEF.md
# Operand Addressing-Mode Fetch Unit

This block produces the second source operand of a two-operand add-style instruction. A caller presents a mode code, two register indices, an instruction constant and a scale step `d`, then pulses `start`. The unit reads the two named registers through combinational read ports, forms an effective address from them, and fetches the operand from a word memory over a valid/ready request channel. It returns the operand with a one-cycle `op_done` strobe. For the post-increment and pre-decrement modes it also returns the updated base register through its own write-enable in that same cycle.

Register and constant operands finish without touching memory. The chained-indirect mode needs two memory reads in sequence, and the second read is addressed by the word that the first read returns. All operands, the constant and `d` are sampled in the cycle that `start` is accepted. Later changes on those inputs have no effect on the operation in flight. The same holds for a new `start` that arrives while the unit is busy.

Top module: `opfetch_am_unit`

## Requirements
- R1: Mode code 0 (register) returns the value of the register named by `base_idx`. It issues no memory request. `op_done` rises on the first clock edge after the accepting edge.
- R2: Mode code 1 (constant) returns `imm`, issues no memory request, and finishes on the first clock edge after the accepting edge.
- R3: Mode code 2 (absolute) issues one read at the low `ADDR_W` bits of `imm`, and returns the word that comes back.
- R4: Mode code 3 (register-pointer) issues one read at the base register value. Mode code 4 (offset) issues one read at `imm` plus the base register value.
- R5: Mode code 5 (two-register sum) issues one read at the base register value plus the index register value.
- R6: Mode code 6 (chained indirect) first reads at the base register value. It then reads at the low `ADDR_W` bits of the returned word and returns the second word. Exactly two requests are made, and `op_done` follows the second response.
- R7: Mode code 7 (post-increment) reads at the old base register value. In the `op_done` cycle it asserts `wb_en` with `wb_idx` equal to `base_idx` and `wb_data` equal to base + `d`.
- R8: Mode code 8 (pre-decrement) reads at base − `d`. In the `op_done` cycle it asserts `wb_en` with `wb_data` equal to base − `d`.
- R9: Mode code 9 (scaled) reads at `imm` + base + index × `d`.
- R10: Address sums wrap modulo 2^`ADDR_W`, and writeback sums wrap modulo 2^`DATA_W`.
- R11: Mode codes 10 to 15 raise `illegal_mode` together with `op_done` on the next edge. They issue no memory request, return an operand of 0, and do not assert `wb_en`.
- R12: Once `mem_req_valid` is raised, it stays high with an unchanged `mem_req_addr` until `mem_req_ready` is seen.
- R13: A `start` pulse while `busy` is high is ignored. The result, the requests and the number of `op_done` pulses are those of the operation already running.
- R14: `wb_en` is asserted only for mode codes 7 and 8, and only in a cycle in which `op_done` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin an operand fetch when not busy |
| mode | input | 4 | Addressing-mode code |
| base_idx | input | REG_IDX_W | Base register index |
| index_idx | input | REG_IDX_W | Index register index |
| imm | input | DATA_W | Instruction constant or displacement |
| scale_d | input | SCALE_W | Step / scale value d |
| busy | output | 1 | Operation in progress |
| rf_a_idx | output | REG_IDX_W | Register read port A index |
| rf_a_data | input | DATA_W | Register read port A data |
| rf_b_idx | output | REG_IDX_W | Register read port B index |
| rf_b_data | input | DATA_W | Register read port B data |
| mem_req_valid | output | 1 | Memory read request valid |
| mem_req_ready | input | 1 | Memory read request accepted |
| mem_req_addr | output | ADDR_W | Memory read address |
| mem_rsp_valid | input | 1 | Memory read data valid |
| mem_rsp_data | input | DATA_W | Memory read data |
| op_value | output | DATA_W | Fetched operand |
| op_done | output | 1 | One-cycle completion strobe |
| illegal_mode | output | 1 | Unused mode code seen |
| wb_en | output | 1 | Base register update enable |
| wb_idx | output | REG_IDX_W | Base register update index |
| wb_data | output | DATA_W | Base register update value |

## Verification
The hardest situation to reach is the chained-indirect read with a stalled request channel. In that case the second address exists only inside the unit, because it comes from memory data. The bench reaches it with a memory model whose contents are a computed function of the address, so the expected second address and operand follow arithmetically. Pseudo-random `mem_req_ready` stalls are applied on alternate passes. A second hard case is a `start` that arrives mid-operation. The bench injects one during memory-mode operations with conflicting inputs, then checks that the result, the request count and the `op_done` count are all unchanged.

// File: rtl/opfetch_am_pkg.sv
package opfetch_am_pkg;

   typedef enum logic [3:0] {
      AM_REG     = 4'd0,
      AM_CONST   = 4'd1,
      AM_ABS     = 4'd2,
      AM_RPTR    = 4'd3,
      AM_OFFS    = 4'd4,
      AM_RSUM    = 4'd5,
      AM_CHAIN   = 4'd6,
      AM_POSTINC = 4'd7,
      AM_PREDEC  = 4'd8,
      AM_SCALED  = 4'd9
   } am_mode_e;

   typedef enum logic [1:0] {
      FS_IDLE = 2'd0,
      FS_REQ  = 2'd1,
      FS_WAIT = 2'd2
   } fetch_state_e;

   function automatic logic mode_is_legal(input logic [3:0] m);
      return m <= 4'd9;
   endfunction

endpackage

// File: rtl/opfetch_am_scale.sv
module opfetch_am_scale #(
   parameter int IW        = 16,
   parameter int SW        = 4,
   parameter int MUL_STYLE = 1
) (
   input  logic [IW-1:0] index_val,
   input  logic [SW-1:0] step,
   output logic [IW-1:0] product
);

   generate
      if (MUL_STYLE == 0) begin : g_direct
         logic [IW+SW-1:0] full;
         assign full    = index_val * step;
         assign product = full[IW-1:0];
      end else begin : g_shift_add
         logic [IW-1:0] part [SW+1];
         assign part[0] = '0;
         for (genvar k = 0; k < SW; k++) begin : g_term
            assign part[k+1] = part[k] + (step[k] ? (index_val << k) : '0);
         end
         assign product = part[SW];
      end
   endgenerate

endmodule

// File: rtl/opfetch_am_addr.sv
module opfetch_am_addr
   import opfetch_am_pkg::*;
#(
   parameter int DATA_W    = 16,
   parameter int ADDR_W    = 8,
   parameter int SCALE_W   = 4,
   parameter int MUL_STYLE = 1
) (
   input  logic [3:0]        mode,
   input  logic [DATA_W-1:0] base_val,
   input  logic [DATA_W-1:0] index_val,
   input  logic [DATA_W-1:0] imm,
   input  logic [SCALE_W-1:0] step,
   output logic [ADDR_W-1:0] eff_addr,
   output logic [DATA_W-1:0] upd_val,
   output logic [DATA_W-1:0] direct_val,
   output logic              legal,
   output logic              needs_mem,
   output logic              chained,
   output logic              has_wb
);

   logic [DATA_W-1:0] step_ext;
   logic [DATA_W-1:0] scaled;
   logic [DATA_W-1:0] addr_sum;

   assign step_ext = DATA_W'(step);

   opfetch_am_scale #(
      .IW(DATA_W), .SW(SCALE_W), .MUL_STYLE(MUL_STYLE)
   ) u_scale (
      .index_val(index_val),
      .step     (step),
      .product  (scaled)
   );

   always_comb begin
      addr_sum   = '0;
      direct_val = '0;
      needs_mem  = 1'b1;
      unique case (mode)
         AM_REG:     begin direct_val = base_val; needs_mem = 1'b0; end
         AM_CONST:   begin direct_val = imm;      needs_mem = 1'b0; end
         AM_ABS:     addr_sum = imm;
         AM_RPTR:    addr_sum = base_val;
         AM_OFFS:    addr_sum = imm + base_val;
         AM_RSUM:    addr_sum = base_val + index_val;
         AM_CHAIN:   addr_sum = base_val;
         AM_POSTINC: addr_sum = base_val;
         AM_PREDEC:  addr_sum = base_val - step_ext;
         AM_SCALED:  addr_sum = imm + base_val + scaled;
         default:    needs_mem = 1'b0;
      endcase
   end

   assign eff_addr = addr_sum[ADDR_W-1:0];
   assign upd_val  = (mode == AM_PREDEC) ? (base_val - step_ext) : (base_val + step_ext);
   assign legal    = mode_is_legal(mode);
   assign chained  = (mode == AM_CHAIN);
   assign has_wb   = (mode == AM_POSTINC) || (mode == AM_PREDEC);

endmodule

// File: rtl/opfetch_am_seq.sv
module opfetch_am_seq
   import opfetch_am_pkg::*;
#(
   parameter int DATA_W    = 16,
   parameter int ADDR_W    = 8,
   parameter int REG_IDX_W = 3
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 start,
   input  logic                 legal,
   input  logic                 needs_mem,
   input  logic                 chained,
   input  logic                 has_wb,
   input  logic [ADDR_W-1:0]    eff_addr,
   input  logic [DATA_W-1:0]    direct_val,
   input  logic [DATA_W-1:0]    upd_val,
   input  logic [REG_IDX_W-1:0] upd_idx,
   input  logic                 mem_req_ready,
   input  logic                 mem_rsp_valid,
   input  logic [DATA_W-1:0]    mem_rsp_data,
   output logic                 busy,
   output logic                 mem_req_valid,
   output logic [ADDR_W-1:0]    mem_req_addr,
   output logic [DATA_W-1:0]    op_value,
   output logic                 op_done,
   output logic                 illegal_mode,
   output logic                 wb_en,
   output logic [REG_IDX_W-1:0] wb_idx,
   output logic [DATA_W-1:0]    wb_data
);

   fetch_state_e       state;
   logic [ADDR_W-1:0]  addr_q;
   logic               chain_q;
   logic               wbflag_q;
   logic               accept;

   assign busy          = (state != FS_IDLE);
   assign accept        = start && (state == FS_IDLE);
   assign mem_req_valid = (state == FS_REQ);
   assign mem_req_addr  = addr_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state        <= FS_IDLE;
         addr_q       <= '0;
         chain_q      <= 1'b0;
         wbflag_q     <= 1'b0;
         op_value     <= '0;
         op_done      <= 1'b0;
         illegal_mode <= 1'b0;
         wb_en        <= 1'b0;
         wb_idx       <= '0;
         wb_data      <= '0;
      end else begin
         op_done      <= 1'b0;
         illegal_mode <= 1'b0;
         wb_en        <= 1'b0;
         unique case (state)
            FS_IDLE: begin
               if (accept) begin
                  if (!legal) begin
                     op_done      <= 1'b1;
                     illegal_mode <= 1'b1;
                     op_value     <= '0;
                  end else if (!needs_mem) begin
                     op_done  <= 1'b1;
                     op_value <= direct_val;
                  end else begin
                     addr_q   <= eff_addr;
                     chain_q  <= chained;
                     wbflag_q <= has_wb;
                     wb_idx   <= upd_idx;
                     wb_data  <= upd_val;
                     state    <= FS_REQ;
                  end
               end
            end
            FS_REQ: begin
               if (mem_req_ready) state <= FS_WAIT;
            end
            FS_WAIT: begin
               if (mem_rsp_valid) begin
                  if (chain_q) begin
                     chain_q <= 1'b0;
                     addr_q  <= mem_rsp_data[ADDR_W-1:0];
                     state   <= FS_REQ;
                  end else begin
                     op_value <= mem_rsp_data;
                     op_done  <= 1'b1;
                     wb_en    <= wbflag_q;
                     state    <= FS_IDLE;
                  end
               end
            end
            default: state <= FS_IDLE;
         endcase
      end
   end

   // R12
   req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));

   // R14
   wb_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wb_en |-> op_done);

   // R11
   illegal_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
      illegal_mode |-> (op_done && !wb_en && op_value == '0));

   // R11
   illegal_noreq_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !busy && !legal) |=> !mem_req_valid);

   // R1
   fast_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !busy && legal && !needs_mem) |=> (op_done && !busy));

endmodule

// File: rtl/opfetch_am_unit.sv
module opfetch_am_unit #(
   parameter int DATA_W    = 16,
   parameter int ADDR_W    = 8,
   parameter int REG_IDX_W = 3,
   parameter int SCALE_W   = 4,
   parameter int MUL_STYLE = 1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 start,
   input  logic [3:0]           mode,
   input  logic [REG_IDX_W-1:0] base_idx,
   input  logic [REG_IDX_W-1:0] index_idx,
   input  logic [DATA_W-1:0]    imm,
   input  logic [SCALE_W-1:0]   scale_d,
   output logic                 busy,
   output logic [REG_IDX_W-1:0] rf_a_idx,
   input  logic [DATA_W-1:0]    rf_a_data,
   output logic [REG_IDX_W-1:0] rf_b_idx,
   input  logic [DATA_W-1:0]    rf_b_data,
   output logic                 mem_req_valid,
   input  logic                 mem_req_ready,
   output logic [ADDR_W-1:0]    mem_req_addr,
   input  logic                 mem_rsp_valid,
   input  logic [DATA_W-1:0]    mem_rsp_data,
   output logic [DATA_W-1:0]    op_value,
   output logic                 op_done,
   output logic                 illegal_mode,
   output logic                 wb_en,
   output logic [REG_IDX_W-1:0] wb_idx,
   output logic [DATA_W-1:0]    wb_data
);

   generate
      if (ADDR_W > DATA_W) begin : g_bad_addr
         $error("ADDR_W must not exceed DATA_W");
      end
      if (SCALE_W > DATA_W || SCALE_W < 1) begin : g_bad_scale
         $error("SCALE_W must lie in 1..DATA_W");
      end
      if (MUL_STYLE != 0 && MUL_STYLE != 1) begin : g_bad_style
         $error("MUL_STYLE must be 0 or 1");
      end
   endgenerate

   logic [ADDR_W-1:0] eff_addr;
   logic [DATA_W-1:0] upd_val;
   logic [DATA_W-1:0] direct_val;
   logic              legal, needs_mem, chained, has_wb;

   assign rf_a_idx = base_idx;
   assign rf_b_idx = index_idx;

   opfetch_am_addr #(
      .DATA_W(DATA_W), .ADDR_W(ADDR_W), .SCALE_W(SCALE_W), .MUL_STYLE(MUL_STYLE)
   ) u_addr (
      .mode      (mode),
      .base_val  (rf_a_data),
      .index_val (rf_b_data),
      .imm       (imm),
      .step      (scale_d),
      .eff_addr  (eff_addr),
      .upd_val   (upd_val),
      .direct_val(direct_val),
      .legal     (legal),
      .needs_mem (needs_mem),
      .chained   (chained),
      .has_wb    (has_wb)
   );

   opfetch_am_seq #(
      .DATA_W(DATA_W), .ADDR_W(ADDR_W), .REG_IDX_W(REG_IDX_W)
   ) u_seq (
      .clk          (clk),
      .rst_n        (rst_n),
      .start        (start),
      .legal        (legal),
      .needs_mem    (needs_mem),
      .chained      (chained),
      .has_wb       (has_wb),
      .eff_addr     (eff_addr),
      .direct_val   (direct_val),
      .upd_val      (upd_val),
      .upd_idx      (base_idx),
      .mem_req_ready(mem_req_ready),
      .mem_rsp_valid(mem_rsp_valid),
      .mem_rsp_data (mem_rsp_data),
      .busy         (busy),
      .mem_req_valid(mem_req_valid),
      .mem_req_addr (mem_req_addr),
      .op_value     (op_value),
      .op_done      (op_done),
      .illegal_mode (illegal_mode),
      .wb_en        (wb_en),
      .wb_idx       (wb_idx),
      .wb_data      (wb_data)
   );

endmodule

// File: tb/opfetch_am_unit_test.sv
module opfetch_am_unit_test;

   localparam int DW = 16;
   localparam int AW = 8;
   localparam int RW = 3;
   localparam int SW = 4;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          start = 1'b0;
   logic [3:0]    mode = '0;
   logic [RW-1:0] base_idx = '0, index_idx = '0;
   logic [DW-1:0] imm = '0;
   logic [SW-1:0] scale_d = '0;
   logic          busy;
   logic [RW-1:0] rf_a_idx, rf_b_idx;
   logic [DW-1:0] rf_a_data, rf_b_data;
   logic          mem_req_valid;
   logic          mem_req_ready = 1'b1;
   logic [AW-1:0] mem_req_addr;
   logic          mem_rsp_valid = 1'b0;
   logic [DW-1:0] mem_rsp_data = '0;
   logic [DW-1:0] op_value;
   logic          op_done, illegal_mode, wb_en;
   logic [RW-1:0] wb_idx;
   logic [DW-1:0] wb_data;

   logic [DW-1:0] rf [8];
   int            checks = 0;
   int            errors = 0;
   int            nreq = 0;
   logic [AW-1:0] req_a [2];
   logic [15:0]   lfsr = 16'hACE1;
   logic          stall_on = 1'b0;
   int            cyc = 0;

   always #5 clk = ~clk;

   assign rf_a_data = rf[rf_a_idx];
   assign rf_b_data = rf[rf_b_idx];

   opfetch_am_unit uut (
      .clk(clk), .rst_n(rst_n), .start(start), .mode(mode),
      .base_idx(base_idx), .index_idx(index_idx), .imm(imm), .scale_d(scale_d),
      .busy(busy), .rf_a_idx(rf_a_idx), .rf_a_data(rf_a_data),
      .rf_b_idx(rf_b_idx), .rf_b_data(rf_b_data),
      .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
      .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
      .mem_rsp_data(mem_rsp_data), .op_value(op_value), .op_done(op_done),
      .illegal_mode(illegal_mode), .wb_en(wb_en), .wb_idx(wb_idx), .wb_data(wb_data)
   );

   function automatic logic [DW-1:0] memf(input logic [AW-1:0] a);
      logic [DW-1:0] x;
      x = DW'(a) * 16'd691;
      return x ^ 16'h5A3C;
   endfunction

   function automatic logic [15:0] nxt(input logic [15:0] v);
      return {v[14:0], v[15] ^ v[13] ^ v[12] ^ v[10]};
   endfunction

   // memory model: one-cycle response after an accepted request
   always @(posedge clk) begin
      mem_rsp_valid <= mem_req_valid && mem_req_ready;
      mem_rsp_data  <= memf(mem_req_addr);
      if (mem_req_valid && mem_req_ready) begin
         if (nreq < 2) req_a[nreq] <= mem_req_addr;
         nreq <= nreq + 1;
      end
   end

   always @(negedge clk) begin
      lfsr          <= nxt(lfsr);
      mem_req_ready <= stall_on ? lfsr[3] : 1'b1;
   end

   task automatic check(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic finish_run();
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > 190000) begin
         checks++;
         errors++;
         $display("FAIL watchdog actual=%0d expected=%0d", cyc, 190000);
         finish_run();
      end
   end

   task automatic run_op(input logic [3:0] m, input logic [RW-1:0] b, input logic [RW-1:0] x,
                         input logic [DW-1:0] k, input logic [SW-1:0] d, input logic intrude);
      logic [DW-1:0] bv, xv, dx, s1, exp_val, exp_wb;
      logic [AW-1:0] a1, a2;
      int exp_n, dones, first_at, n;
      logic exp_wben, exp_ill, mem_mode, got_wb, got_ill;
      logic [DW-1:0] got_val, got_wbd;
      logic [RW-1:0] got_wbi;
      bv = rf[b]; xv = rf[x]; dx = DW'(d);
      exp_ill = (m > 4'd9); exp_wben = (m == 4'd7) || (m == 4'd8);
      exp_n = 1; s1 = '0; exp_wb = bv + dx;
      case (m)
         4'd0: begin exp_n = 0; exp_val = bv; end
         4'd1: begin exp_n = 0; exp_val = k; end
         4'd2: s1 = k;
         4'd3: s1 = bv;
         4'd4: s1 = k + bv;
         4'd5: s1 = bv + xv;
         4'd6: begin s1 = bv; exp_n = 2; end
         4'd7: s1 = bv;
         4'd8: begin s1 = bv - dx; exp_wb = bv - dx; end
         4'd9: s1 = k + bv + DW'(xv * dx);
         default: begin exp_n = 0; exp_val = '0; end
      endcase
      a1 = s1[AW-1:0];
      a2 = memf(a1);
      a2 = a2[AW-1:0];
      mem_mode = (exp_n > 0);
      if (exp_n == 1) exp_val = memf(a1);
      if (exp_n == 2) exp_val = memf(a2);

      @(negedge clk);
      nreq = 0;
      mode = m; base_idx = b; index_idx = x; imm = k; scale_d = d; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      mode = 4'hF; imm = ~k; scale_d = ~d; base_idx = ~b; index_idx = ~x;
      dones = 0; first_at = 0; got_val = '0; got_wb = 0; got_wbd = '0; got_wbi = '0; got_ill = 0;
      n = 1;
      while (n < 60) begin
         if (intrude && n == 2 && mem_mode) begin
            start = 1'b1; mode = 4'd1;
         end else start = 1'b0;
         if (op_done) begin
            dones++;
            if (first_at == 0) first_at = n;
            got_val = op_value; got_wb = wb_en; got_wbd = wb_data; got_wbi = wb_idx;
            got_ill = illegal_mode;
         end
         if (!op_done && first_at != 0 && n > first_at + 2) break;
         @(negedge clk);
         n++;
      end
      start = 1'b0;
      if (first_at == 0) begin
         checks++; errors++;
         $display("FAIL R1 timeout mode=%0d actual=0 expected=1", m);
         return;
      end
      if (exp_ill) begin
         check(got_ill, "R11 illegal flag", 32'(got_ill), 1);
         check(got_val == '0, "R11 zero operand", 32'(got_val), 0);
      end else begin
         check(!got_ill, "R11 legal no flag", 32'(got_ill), 0);
         case (m)
            4'd0: check(got_val == exp_val, "R1 reg operand", 32'(got_val), 32'(exp_val));
            4'd1: check(got_val == exp_val, "R2 const operand", 32'(got_val), 32'(exp_val));
            4'd2: check(got_val == exp_val, "R3 abs operand", 32'(got_val), 32'(exp_val));
            4'd3, 4'd4: check(got_val == exp_val, "R4 ptr/offs operand", 32'(got_val), 32'(exp_val));
            4'd5: check(got_val == exp_val, "R5 rsum operand", 32'(got_val), 32'(exp_val));
            4'd6: check(got_val == exp_val, "R6 chain operand", 32'(got_val), 32'(exp_val));
            4'd7: check(got_val == exp_val, "R7 postinc operand", 32'(got_val), 32'(exp_val));
            4'd8: check(got_val == exp_val, "R8 predec operand", 32'(got_val), 32'(exp_val));
            default: check(got_val == exp_val, "R9 scaled operand", 32'(got_val), 32'(exp_val));
         endcase
      end
      check(nreq == exp_n, "R11/R6 request count", 32'(nreq), 32'(exp_n));
      if (exp_n >= 1) check(req_a[0] == a1, "R10 first address wrap", 32'(req_a[0]), 32'(a1));
      if (exp_n == 2) check(req_a[1] == a2, "R6 second address", 32'(req_a[1]), 32'(a2));
      if (!mem_mode) check(first_at == 1, "R1/R2 one-cycle latency", 32'(first_at), 1);
      check(dones == 1, intrude ? "R13 ignored start" : "R13 single done", 32'(dones), 1);
      check(got_wb == exp_wben, "R14 wb_en", 32'(got_wb), 32'(exp_wben));
      if (exp_wben) begin
         check(got_wbd == exp_wb, m == 4'd7 ? "R7 wb data" : "R8 wb data", 32'(got_wbd), 32'(exp_wb));
         check(got_wbi == b, "R7 wb index", 32'(got_wbi), 32'(b));
      end
   endtask

   initial begin
      for (int i = 0; i < 8; i++) rf[i] = '0;
      repeat (3) @(negedge clk);
      // reset state
      check(!busy && !op_done && !mem_req_valid && !wb_en && !illegal_mode,
            "R12 reset idle", {27'd0, busy, op_done, mem_req_valid, wb_en, illegal_mode}, 0);
      rst_n = 1'b1;
      @(negedge clk);
      for (int pass = 0; pass < 2; pass++) begin
         stall_on = (pass == 1);
         for (int m = 0; m < 16; m++) begin
            for (int b = 0; b < 8; b++) begin
               for (int i = 0; i < 8; i++) begin
                  lfsr = nxt(lfsr);
                  rf[i] = (i == 7) ? 16'hFFFF : (lfsr ^ 16'(i * 4663));
               end
               for (int x = 0; x < 8; x += 3) begin
                  for (int dd = 0; dd < 4; dd++) begin
                     logic [SW-1:0] dv;
                     dv = (dd == 3) ? 4'hF : SW'(dd * 3 + pass);
                     lfsr = nxt(lfsr);
                     run_op(4'(m), 3'(b), 3'(x), lfsr ^ 16'hF0F0, dv, (b == x));
                  end
               end
            end
         end
      end
      finish_run();
   end

endmodule